// File: doc/BRIEF.md
# Carry-Save-by-Carry-Save Multiplier

This block multiplies two operands that both arrive in carry-save form: a multiplier R held as a sum word and a carry word, and a multiplicand X held the same way. It is meant to sit inside an iterative reciprocal datapath, where both the running estimate and the correction factor leave the previous stage unresolved. No carry-propagate adder is placed on either input pair, and none on the output. The result leaves the block as a sum and carry pair that a later stage may resolve or feed onward.

The product is split as (rs + rc)·xs + (rs + rc)·xc. The R pair goes straight into a radix-4 recoder. The recoder applies two local transfer steps and emits signed digits in the range −2..+2. One set of digits drives two partial-product generators, one for xs and one for xc. Each generator's rows are reduced by its own tree of 3:2 counters to a pair. A final 4:2 compressor merges the two pairs into one. The block is purely combinational. The output width is 2W+2 bits, so the full product of two (W+1)-bit values always fits.

Top module: `redundant_mult`

## Requirements
- R1: With all operand words taken as unsigned W-bit values, the output pair satisfies p_sum + p_carry = (r_sum + r_carry)·(x_sum + x_carry) modulo 2^(2W+2). This is the exact product.
- R2: When all four inputs are all-ones, the output pair sums to the exact value (2^(W+1) − 2)².
- R3: If either operand pair is zero in both words, the output pair sums to zero.
- R4: Swapping the two words of R, or swapping the two words of X, leaves p_sum + p_carry unchanged.
- R5: R enters the multiply only as radix-4 digits in −2..+2 whose weighted sum is r_sum + r_carry. Two R pairs with the same numeric sum therefore give the same output sum.
- R6: Each half of X contributes its own sub-product. With x_carry = 0 the output sums to R·x_sum, and with x_sum = 0 it sums to R·x_carry.
- R7: Bit 0 of p_carry is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| r_sum | input | W | Sum word of the carry-save multiplier R |
| r_carry | input | W | Carry word of R, same weight as r_sum |
| x_sum | input | W | Sum word of the carry-save multiplicand X |
| x_carry | input | W | Carry word of X, same weight as x_sum |
| p_sum | output | 2W+2 | Sum word of the carry-save product |
| p_carry | output | 2W+2 | Carry word of the carry-save product |

## Verification
In one evaluation, negative-digit correction bits from both partial-product generators can land in the same columns. At the same time, the recoder's transfer carries can ripple into the padded top digits. Inputs at or near all-ones in both pairs provoke this, as do long runs of ones mixed into constrained random words. Each result is judged by adding the two output words and comparing the sum with an exact product computed in the bench. The carry word's least significant bit is also checked.

// File: rtl/rmul_pkg.sv
package rmul_pkg;

  // One signed radix-4 digit in sign/magnitude form: magnitude 1 or 2 is one-hot.
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } digit_t;

  // Rows left after lv layers of 3:2 counters, starting from n rows.
  function automatic int tree_rows(int n, int lv);
    int r;
    r = n;
    for (int i = 0; i < lv; i++) r = 2 * (r / 3) + (r % 3);
    return r;
  endfunction

  // Layers needed to bring n rows down to two.
  function automatic int tree_levels(int n);
    int r;
    int l;
    r = n;
    l = 0;
    while (r > 2) begin
      r = 2 * (r / 3) + (r % 3);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/csa3.sv
module csa3 #(
  parameter int OW = 34
) (
  input  logic [OW-1:0] a,
  input  logic [OW-1:0] b,
  input  logic [OW-1:0] c,
  output logic [OW-1:0] s,
  output logic [OW-1:0] cy
);
  logic [OW-1:0] maj;

  assign s   = a ^ b ^ c;
  assign maj = (a & b) | (a & c) | (b & c);
  assign cy  = {maj[OW-2:0], 1'b0};
endmodule

// File: rtl/cs_recoder.sv
module cs_recoder
  import rmul_pkg::*;
#(
  parameter int W  = 16,
  parameter int ND = 10
) (
  input  logic [W-1:0]             in_s,
  input  logic [W-1:0]             in_c,
  output digit_t [ND-1:0]          dig
);
  localparam int PB = 2 * ND;

  logic [PB-1:0] sp;
  logic [PB-1:0] cp;

  assign sp = PB'(in_s);
  assign cp = PB'(in_c);

  // Level 1: group value v in 0..6 -> residual l in -2..1 plus transfer h in 0..2.
  // Level 2: w = l + h_in in -2..3 -> residual m in -2..1 plus transfer k in 0..1.
  // Digit d = m + k_in lies in -2..+2.
  always_comb begin
    int v;
    int l;
    int h;
    int w;
    int m;
    int k;
    int d;
    int mag;
    int h_in;
    int k_in;
    h_in = 0;
    k_in = 0;
    for (int i = 0; i < ND; i++) begin
      v = 2 * (int'(sp[2*i+1]) + int'(cp[2*i+1])) + int'(sp[2*i]) + int'(cp[2*i]);
      case (v)
        0:       begin l = 0;  h = 0; end
        1:       begin l = 1;  h = 0; end
        2:       begin l = -2; h = 1; end
        3:       begin l = -1; h = 1; end
        4:       begin l = 0;  h = 1; end
        5:       begin l = 1;  h = 1; end
        default: begin l = -2; h = 2; end
      endcase
      w = l + h_in;
      if (w >= 2) begin
        k = 1;
        m = w - 4;
      end else begin
        k = 0;
        m = w;
      end
      d   = m + k_in;
      mag = (d < 0) ? -d : d;
      dig[i].neg = (d < 0);
      dig[i].one = (mag == 1);
      dig[i].two = (mag == 2);
      h_in = h;
      k_in = k;
    end
  end
endmodule

// File: rtl/pp_rows.sv
module pp_rows
  import rmul_pkg::*;
#(
  parameter int W  = 16,
  parameter int ND = 10,
  parameter int OW = 34
) (
  input  digit_t [ND-1:0]          dig,
  input  logic [W-1:0]             mcand,
  output logic [ND:0][OW-1:0]      rows
);
  // Row i holds digit i times mcand at weight 4^i; a negative row is inverted,
  // and its +1 goes into the shared correction row (last row).
  always_comb begin
    logic [OW-1:0] mag;
    logic [OW-1:0] fix;
    fix = '0;
    for (int i = 0; i < ND; i++) begin
      if (dig[i].two)      mag = OW'(mcand) << 1;
      else if (dig[i].one) mag = OW'(mcand);
      else                 mag = '0;
      rows[i] = (dig[i].neg ? ~mag : mag) << (2 * i);
      if (dig[i].neg) fix[2*i] = 1'b1;
    end
    rows[ND] = fix;
  end
endmodule

// File: rtl/csa_tree.sv
module csa_tree
  import rmul_pkg::*;
#(
  parameter int N  = 11,
  parameter int OW = 34
) (
  input  logic [N-1:0][OW-1:0] rows,
  output logic [OW-1:0]        sum,
  output logic [OW-1:0]        carry
);
  localparam int NL = tree_levels(N);

  for (genvar lv = 0; lv < NL; lv++) begin : g_lv
    localparam int NIN  = tree_rows(N, lv);
    localparam int NOUT = tree_rows(N, lv + 1);
    localparam int NG   = NIN / 3;
    localparam int NREM = NIN % 3;

    logic [NIN-1:0][OW-1:0]  cur;
    logic [NOUT-1:0][OW-1:0] nxt;

    if (lv == 0) begin : g_first
      assign cur = rows;
    end else begin : g_next
      assign cur = g_lv[lv-1].nxt;
    end

    for (genvar g = 0; g < NG; g++) begin : g_cnt
      csa3 #(.OW(OW)) u_csa (
        .a  (cur[3*g]),
        .b  (cur[3*g+1]),
        .c  (cur[3*g+2]),
        .s  (nxt[2*g]),
        .cy (nxt[2*g+1])
      );
    end

    for (genvar r = 0; r < NREM; r++) begin : g_pass
      assign nxt[2*NG+r] = cur[3*NG+r];
    end
  end

  assign sum   = g_lv[NL-1].nxt[0];
  assign carry = g_lv[NL-1].nxt[1];
endmodule

// File: rtl/cmp42.sv
module cmp42 #(
  parameter int OW = 34
) (
  input  logic [OW-1:0] a,
  input  logic [OW-1:0] b,
  input  logic [OW-1:0] c,
  input  logic [OW-1:0] d,
  output logic [OW-1:0] s,
  output logic [OW-1:0] cy
);
  logic [OW-1:0] t_s;
  logic [OW-1:0] t_c;

  csa3 #(.OW(OW)) u_lo (.a(a), .b(b), .c(c), .s(t_s), .cy(t_c));
  csa3 #(.OW(OW)) u_hi (.a(t_s), .b(t_c), .c(d), .s(s), .cy(cy));
endmodule

// File: rtl/redundant_mult.sv
module redundant_mult
  import rmul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]     r_sum,
  input  logic [W-1:0]     r_carry,
  input  logic [W-1:0]     x_sum,
  input  logic [W-1:0]     x_carry,
  output logic [2*W+1:0]   p_sum,
  output logic [2*W+1:0]   p_carry
);
  localparam int HALF = (W + 1) / 2;
  localparam int ND   = HALF + 2;
  localparam int OW   = 2 * W + 2;
  localparam int NR   = ND + 1;

  digit_t [ND-1:0]     r_dig;
  logic [NR-1:0][OW-1:0] rows_a;
  logic [NR-1:0][OW-1:0] rows_b;
  logic [OW-1:0]       a_s;
  logic [OW-1:0]       a_c;
  logic [OW-1:0]       b_s;
  logic [OW-1:0]       b_c;

  cs_recoder #(.W(W), .ND(ND)) u_rec (
    .in_s (r_sum),
    .in_c (r_carry),
    .dig  (r_dig)
  );

  pp_rows #(.W(W), .ND(ND), .OW(OW)) u_ppa (.dig(r_dig), .mcand(x_sum),   .rows(rows_a));
  pp_rows #(.W(W), .ND(ND), .OW(OW)) u_ppb (.dig(r_dig), .mcand(x_carry), .rows(rows_b));

  csa_tree #(.N(NR), .OW(OW)) u_tra (.rows(rows_a), .sum(a_s), .carry(a_c));
  csa_tree #(.N(NR), .OW(OW)) u_trb (.rows(rows_b), .sum(b_s), .carry(b_c));

  cmp42 #(.OW(OW)) u_mrg (
    .a  (a_s),
    .b  (a_c),
    .c  (b_s),
    .d  (b_c),
    .s  (p_sum),
    .cy (p_carry)
  );
endmodule

// File: rtl/redundant_mult_chk.sv
module redundant_mult_chk
  import rmul_pkg::*;
#(
  parameter int W = 16
) (
  input logic [W-1:0]               r_sum,
  input logic [W-1:0]               r_carry,
  input logic [W-1:0]               x_sum,
  input logic [W-1:0]               x_carry,
  input logic [2*W+1:0]             p_sum,
  input logic [2*W+1:0]             p_carry,
  input digit_t [(W+1)/2+1:0]       r_dig,
  input logic [2*W+1:0]             a_s,
  input logic [2*W+1:0]             a_c,
  input logic [2*W+1:0]             b_s,
  input logic [2*W+1:0]             b_c
);
  localparam int ND = (W + 1) / 2 + 2;
  localparam int OW = 2 * W + 2;

  logic [OW-1:0]   rv;
  logic [OW-1:0]   xv;
  logic [OW+1:0]   dsum;
  logic [OW+1:0]   term;
  logic            code_ok;

  always_comb begin
    rv = OW'(r_sum) + OW'(r_carry);
    xv = OW'(x_sum) + OW'(x_carry);
    dsum = '0;
    code_ok = 1'b1;
    for (int i = 0; i < ND; i++) begin
      term = (OW+2)'(r_dig[i].two ? 2 : (r_dig[i].one ? 1 : 0)) << (2 * i);
      dsum = r_dig[i].neg ? dsum - term : dsum + term;
      if (r_dig[i].one && r_dig[i].two) code_ok = 1'b0;
      if (r_dig[i].neg && !r_dig[i].one && !r_dig[i].two) code_ok = 1'b0;
    end
  end

  always_comb begin
    assert_exact_product_R1: assert (OW'(p_sum + p_carry) == OW'(rv * xv))
      else $error("product pair does not sum to R*X");
    assert_digit_sum_R5: assert (dsum == (OW+2)'(rv))
      else $error("recoded digits do not weigh up to rs+rc");
    assert_digit_code_R5: assert (code_ok)
      else $error("recoded digit outside -2..+2 encoding");
    assert_sub_xs_R6: assert (OW'(a_s + a_c) == OW'(rv * OW'(x_sum)))
      else $error("xs sub-product wrong");
    assert_sub_xc_R6: assert (OW'(b_s + b_c) == OW'(rv * OW'(x_carry)))
      else $error("xc sub-product wrong");
    assert_carry_lsb_R7: assert (p_carry[0] == 1'b0)
      else $error("carry word bit 0 set");
  end
endmodule

bind redundant_mult redundant_mult_chk #(.W(W)) u_chk (
  .r_sum   (r_sum),
  .r_carry (r_carry),
  .x_sum   (x_sum),
  .x_carry (x_carry),
  .p_sum   (p_sum),
  .p_carry (p_carry),
  .r_dig   (r_dig),
  .a_s     (a_s),
  .a_c     (a_c),
  .b_s     (b_s),
  .b_c     (b_c)
);

// File: tb/redundant_mult_tb.sv
module redundant_mult_tb;
  localparam int W  = 16;
  localparam int OW = 2 * W + 2;

  logic          clk;
  logic [W-1:0]  rs;
  logic [W-1:0]  rc;
  logic [W-1:0]  xs;
  logic [W-1:0]  xc;
  logic [OW-1:0] ps;
  logic [OW-1:0] pc;

  int errors;
  int checks;
  bit done;

  redundant_mult #(.W(W)) u_dut (
    .r_sum   (rs),
    .r_carry (rc),
    .x_sum   (xs),
    .x_carry (xc),
    .p_sum   (ps),
    .p_carry (pc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [OW-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [W-1:0] c, input logic [W-1:0] d);
    logic [OW-1:0] r;
    logic [OW-1:0] x;
    r = OW'(a) + OW'(b);
    x = OW'(c) + OW'(d);
    return r * x;
  endfunction

  task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive away from the rising edge, sample one time unit after it.
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic [W-1:0] d,
                       output logic [OW-1:0] total);
    @(negedge clk);
    rs = a; rc = b; xs = c; xc = d;
    @(posedge clk);
    #1;
    total = ps + pc;
    check("R7", OW'(pc[0]), '0);
  endtask

  initial begin
    logic [OW-1:0] t0;
    logic [OW-1:0] t1;
    logic [W-1:0]  a;
    logic [W-1:0]  b;
    logic [W-1:0]  c;
    logic [W-1:0]  d;
    errors = 0;
    checks = 0;
    done = 1'b0;
    rs = '0; rc = '0; xs = '0; xc = '0;
    void'($urandom(32'd4242));

    // R3: all-zero inputs at start, then each operand pair zeroed
    apply('0, '0, '0, '0, t0);
    check("R3", t0, '0);
    apply('0, '0, 16'hFFFF, 16'h1234, t0);
    check("R3", t0, '0);
    apply(16'hBEEF, 16'h7001, '0, '0, t0);
    check("R3", t0, '0);

    // R2: all-ones in every word, expected (2^(W+1)-2)^2
    apply('1, '1, '1, '1, t0);
    check("R2", t0, OW'((OW'(1) << (W + 1)) - 2) * OW'((OW'(1) << (W + 1)) - 2));
    apply('1, '1, 16'h0001, '0, t0);
    check("R2", t0, model('1, '1, 16'h0001, '0));
    apply(16'h5555, 16'hAAAA, 16'hFFFF, 16'h0001, t0);
    check("R1", t0, model(16'h5555, 16'hAAAA, 16'hFFFF, 16'h0001));

    for (int n = 0; n < 400; n++) begin
      a = W'($urandom());
      b = W'($urandom());
      c = W'($urandom());
      d = W'($urandom());
      if (n % 8 == 0) a = a | 16'hFF00;  // long ones runs in R
      if (n % 8 == 1) b = '1;
      apply(a, b, c, d, t0);
      check("R1", t0, model(a, b, c, d));

      if (n % 4 == 0) begin
        // R4: swap the words of R and of X
        apply(b, a, d, c, t1);
        check("R4", t1, t0);
        // R5: same numeric R from a different pair
        b = b & ~(W'(1) << (W - 1));
        apply(a, b, c, d, t0);
        apply(a ^ b, (a & b) << 1, c, d, t1);
        check("R5", t1, t0);
        check("R5", t1, model(a, b, c, d));
        // R6: one X half at a time
        apply(a, b, c, '0, t0);
        check("R6", t0, model(a, b, c, '0));
        apply(a, b, '0, d, t0);
        check("R6", t0, model(a, b, '0, d));
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule